// File: doc/BRIEF.md
# Indirect Redirection Table Register Window

This block is the memory-mapped front end of an interrupt redirection controller. A bus master reaches its internal registers through three offsets. A select register names one internal register. A data window then reads or writes the register that is selected. A third offset takes end-of-interrupt writes. The internal registers are an identity register, a version register, an arbitration register and a table of 64-bit redirection entries. Each entry is reached as two 32-bit halves.

Writing an entry merges the new half into the stored entry and keeps the read-only status bits. The write then raises a one-cycle service request for the dispatch logic, which lies outside this block. Dispatch reports an accepted level-triggered interrupt by pulsing one bit of a per-pin input, and that pulse sets the entry's remote-pending flag. An end-of-interrupt write is passed out as a one-cycle strobe that carries the vector.

Top module: `ioRedirWindow`

## Requirements
- R1: Only address bits 7:0 are decoded: select at offset 0x00, data window at 0x10, end-of-interrupt at 0x40. Higher address bits have no effect. A read of offset 0x00 returns the select value.
- R2: A data-window access whose size is not 4 bytes is ignored, and a read of that kind returns zero.
- R3: Select values from 0x10 upward address entry index (select − 0x10) >> 1. An even select gives bits 31:0 of the entry and an odd select gives bits 63:32. An index of NUM_PINS or more reads zero, and a write to it changes nothing.
- R4: Select 0x00 (identity) and select 0x02 (arbitration) both read the 4-bit ID at bits 27:24. Select 0x01 reads VERSION in bits 7:0 and NUM_PINS−1 in bits 23:16.
- R5: Writes to the version and arbitration registers have no effect. An identity write stores only bits 27:24.
- R6: Entry bits 12 (delivery status, always 0) and 14 (remote-pending) cannot be written; an entry write keeps their old values. A pulse on remoteSet[i] sets bit 14 of entry i while bit 15 (trigger: 1 = level) is 1.
- R7: An entry write that leaves bit 15 at 0 (edge) clears bit 14.
- R8: Every accepted entry write raises serviceReq for exactly the following cycle.
- R9: A 4-byte write to offset 0x40 raises eoiValid for one cycle, with eoiVector equal to write bits 7:0. This happens only when VERSION is 0x20; other sizes are ignored.
- R10: After reset the select register and ID are zero, and every entry reads 0x0001_0000 (mask bit 16 set) in its low half and zero in its high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| busSize | input | 3 | Access size in bytes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational during a read access |
| remoteSet | input | NUM_PINS | Per-pin remote-pending set pulses from dispatch |
| serviceReq | output | 1 | One-cycle pulse after an entry write |
| eoiValid | output | 1 | End-of-interrupt strobe |
| eoiVector | output | 8 | Vector of the end-of-interrupt write |

## Verification
The remote-pending flag is hard to reach because the bus cannot write it. The bench first programs an entry as level-triggered, then pulses that pin's remoteSet input, and reads the flag back through the window. Next it writes the entry again with bit 14 cleared in the write data, which must leave the flag set. Finally it rewrites the entry as edge-triggered, which must clear the flag.

// File: rtl/ioRedirPkg.sv
package ioRedirPkg;
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] OFS_EOI = 8'h40;
  localparam logic [7:0] REG_ID  = 8'h00;
  localparam logic [7:0] REG_VER = 8'h01;
  localparam logic [7:0] REG_ARB = 8'h02;
  localparam logic [7:0] TBL_BASE = 8'h10;
  localparam logic [63:0] ENTRY_RW = 64'hFF00_0000_0001_AFFF;
  localparam logic [63:0] ENTRY_RO = 64'h0000_0000_0000_5000;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    RD_NONE, RD_SEL, RD_ID, RD_VER, RD_ENTRY
  } rdSrcT;

  typedef struct packed {
    logic       selWr;
    logic       idWr;
    logic       entryWr;
    logic       entryHi;
    logic [7:0] entryIdx;
    logic       eoiWr;
    rdSrcT      rdSrc;
  } winStrobeT;
endpackage

// File: rtl/ioRedirCtrl.sv
module ioRedirCtrl
  import ioRedirPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic [7:0]        selReg,
  output winStrobeT         strb
);
  logic [7:0] lowAddr;
  logic sizeOk, isSel, isWin, isEoi, winAcc, entryHit;
  logic [7:0] relSel;

  assign lowAddr = busAddr[7:0];
  assign sizeOk  = (busSize == 3'd4);
  assign isSel   = (lowAddr == OFS_SEL);
  assign isWin   = (lowAddr == OFS_WIN);
  assign isEoi   = (lowAddr == OFS_EOI);
  assign winAcc  = busValid && isWin && sizeOk;
  assign relSel  = selReg - TBL_BASE;
  assign entryHit = (selReg >= TBL_BASE) && ({1'b0, relSel[7:1]} < 8'(NUM_PINS));

  always_comb begin
    strb = '0;
    strb.entryIdx = {1'b0, relSel[7:1]};
    strb.entryHi  = selReg[0];
    strb.selWr    = busValid && busWrite && isSel;
    strb.idWr     = winAcc && busWrite && (selReg == REG_ID);
    strb.entryWr  = winAcc && busWrite && entryHit;
    strb.eoiWr    = busValid && busWrite && isEoi && sizeOk && (VERSION == 8'h20);
    strb.rdSrc    = RD_NONE;
    if (busValid && !busWrite) begin
      if (isSel) strb.rdSrc = RD_SEL;
      else if (winAcc) begin
        if (selReg == REG_ID || selReg == REG_ARB) strb.rdSrc = RD_ID;
        else if (selReg == REG_VER) strb.rdSrc = RD_VER;
        else if (entryHit) strb.rdSrc = RD_ENTRY;
      end
    end
  end

  AST_WIN_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.entryWr || strb.idWr) |-> (busSize == 3'd4)); // R2
  AST_EOI_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    strb.eoiWr |-> (busSize == 3'd4 && busAddr[7:0] == OFS_EOI)); // R9
endmodule

// File: rtl/ioRedirData.sv
module ioRedirData
  import ioRedirPkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic                clk,
  input  logic                rstN,
  input  winStrobeT           strb,
  input  logic [31:0]         busWdata,
  input  logic [NUM_PINS-1:0] remoteSet,
  output logic [7:0]          selReg,
  output logic [31:0]         busRdata,
  output logic                serviceReq,
  output logic                eoiValid,
  output logic [7:0]          eoiVector
);
  localparam int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [3:0]  idReg;
  logic [63:0] tbl    [NUM_PINS];
  logic [63:0] tblNxt [NUM_PINS];
  logic [IW-1:0] wIdx;

  assign wIdx = strb.entryIdx[IW-1:0];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_entry
    logic [63:0] merged;
    always_comb begin
      merged = strb.entryHi ? {busWdata, tbl[i][31:0]} : {tbl[i][63:32], busWdata};
      tblNxt[i] = tbl[i];
      if (strb.entryWr && strb.entryIdx == 8'(i)) begin
        tblNxt[i] = (merged & ENTRY_RW) | (tbl[i] & ENTRY_RO);
        if (!tblNxt[i][15]) tblNxt[i][14] = 1'b0;
      end
      if (remoteSet[i] && tblNxt[i][15]) tblNxt[i][14] = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (!rstN) tbl[i] <= ENTRY_RST;
      else       tbl[i] <= tblNxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg     <= '0;
      idReg      <= '0;
      serviceReq <= 1'b0;
      eoiValid   <= 1'b0;
      eoiVector  <= '0;
    end else begin
      if (strb.selWr) selReg <= busWdata[7:0];
      if (strb.idWr)  idReg  <= busWdata[27:24];
      serviceReq <= strb.entryWr;
      eoiValid   <= strb.eoiWr;
      if (strb.eoiWr) eoiVector <= busWdata[7:0];
    end
  end

  always_comb begin
    case (strb.rdSrc)
      RD_SEL:   busRdata = {24'h0, selReg};
      RD_ID:    busRdata = {4'h0, idReg, 24'h0};
      RD_VER:   busRdata = {8'h0, 8'(NUM_PINS - 1), 8'h0, VERSION};
      RD_ENTRY: busRdata = strb.entryHi ? tbl[wIdx][63:32] : tbl[wIdx][31:0];
      default:  busRdata = '0;
    endcase
  end

  AST_SERVICE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.entryWr |=> serviceReq); // R8
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.entryWr && !strb.entryHi && !busWdata[15]) |=> !tbl[$past(wIdx)][14]); // R7
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.idWr) |-> $stable(idReg)); // R5
  AST_EOI_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    eoiValid |-> $past(strb.eoiWr)); // R9
endmodule

// File: rtl/ioRedirWindow.sv
module ioRedirWindow
  import ioRedirPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [2:0]          busSize,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_PINS-1:0] remoteSet,
  output logic                serviceReq,
  output logic                eoiValid,
  output logic [7:0]          eoiVector
);
  winStrobeT  strb;
  logic [7:0] selReg;

  ioRedirCtrl #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .selReg(selReg), .strb(strb)
  );

  ioRedirData #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .remoteSet(remoteSet), .selReg(selReg), .busRdata(busRdata),
    .serviceReq(serviceReq), .eoiValid(eoiValid), .eoiVector(eoiVector)
  );
endmodule

// File: tb/ioRedirWindow_tb.sv
module ioRedirWindow_tb;
  localparam int NP = 24;
  logic clk = 0, rstN = 0;
  logic busValid = 0, busWrite = 0;
  logic [11:0] busAddr = 0;
  logic [2:0] busSize = 4;
  logic [31:0] busWdata = 0, busRdata;
  logic [NP-1:0] remoteSet = 0;
  logic serviceReq, eoiValid;
  logic [7:0] eoiVector;
  int total = 0, bad = 0;
  bit doneFlag = 0;

  always #10 clk = ~clk;

  ioRedirWindow u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata),
    .remoteSet(remoteSet), .serviceReq(serviceReq), .eoiValid(eoiValid),
    .eoiVector(eoiVector)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [2:0] sz, logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busSize = sz; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a; busSize = sz;
    #1 d = busRdata;
    @(negedge clk);
    busValid = 0;
  endtask

  task automatic rdSel(logic [7:0] s, output logic [31:0] d);
    wr(12'h000, 4, {24'h0, s});
    rd(12'h010, 4, d);
  endtask

  task automatic tReset();
    logic [31:0] d;
    rd(12'h000, 4, d);  check("R10 select", d, 0);
    rdSel(8'h00, d);    check("R10 id", d, 0);
    rdSel(8'h10, d);    check("R10 entry0 lo", d, 32'h0001_0000);
    rdSel(8'h11, d);    check("R10 entry0 hi", d, 0);
  endtask

  task automatic tDecode();
    logic [31:0] d;
    wr(12'hF00, 4, 32'h0000_0033);
    rd(12'h300, 4, d);  check("R1 high address bits ignored", d, 32'h33);
  endtask

  task automatic tRegs();
    logic [31:0] d;
    rdSel(8'h01, d);    check("R4 version", d, 32'h0017_0020);
    wr(12'h010, 4, 32'hFFFF_FFFF);
    rd(12'h010, 4, d);  check("R5 version write ignored", d, 32'h0017_0020);
    wr(12'h000, 4, 32'h0);
    wr(12'h010, 4, 32'hFFFF_FFFF);
    rd(12'h010, 4, d);  check("R5 id masked", d, 32'h0F00_0000);
    wr(12'h000, 4, 32'h2);
    wr(12'h010, 4, 32'h0);
    rd(12'h010, 4, d);  check("R4 arb reads id", d, 32'h0F00_0000);
    rd(12'h010, 2, d);  check("R2 short read zero", d, 0);
  endtask

  task automatic tEntries();
    logic [31:0] d;
    wr(12'h000, 4, 32'h13);          // entry 1 high
    wr(12'h010, 4, 32'hAB00_0000);
    check("R8 service after write", {31'h0, serviceReq}, 1);
    @(negedge clk);
    check("R8 service one cycle", {31'h0, serviceReq}, 0);
    wr(12'h000, 4, 32'h12);          // entry 1 low
    wr(12'h010, 4, 32'h0000_0041);
    rd(12'h010, 4, d);  check("R3 even half", d, 32'h41);
    wr(12'h000, 4, 32'h13);
    rd(12'h010, 4, d);  check("R3 odd half", d, 32'hAB00_0000);
    wr(12'h010, 2, 32'h1100_0000);
    rd(12'h010, 4, d);  check("R2 short write ignored", d, 32'hAB00_0000);
    wr(12'h000, 4, 32'h10 + 2*NP);
    wr(12'h010, 4, 32'h0000_0055);
    rd(12'h010, 4, d);  check("R3 out of range reads zero", d, 0);
    check("R3 out of range no service", {31'h0, serviceReq}, 0);
    rdSel(8'h10 + 2*(NP-1), d); check("R3 last entry untouched", d, 32'h0001_0000);
  endtask

  task automatic tRemote();
    logic [31:0] d;
    wr(12'h000, 4, 32'h14);          // entry 2 low
    wr(12'h010, 4, 32'h0000_D062);   // level, bits 14 and 12 written as 1
    rd(12'h010, 4, d);  check("R6 ro bits not writable", d, 32'h0000_8062);
    @(negedge clk); remoteSet = 24'h4;
    @(negedge clk); remoteSet = 0;
    rd(12'h010, 4, d);  check("R6 remote set", d, 32'h0000_C062);
    wr(12'h010, 4, 32'h0000_8063);
    rd(12'h010, 4, d);  check("R6 remote kept on write", d, 32'h0000_C063);
    wr(12'h010, 4, 32'h0000_0063);
    rd(12'h010, 4, d);  check("R7 edge clears remote", d, 32'h0000_0063);
    @(negedge clk); remoteSet = 24'h4;
    @(negedge clk); remoteSet = 0;
    rd(12'h010, 4, d);  check("R6 no set when edge", d, 32'h0000_0063);
  endtask

  task automatic tEoi();
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = 12'h040; busSize = 4; busWdata = 32'h5A;
    @(negedge clk);
    busValid = 0; busWrite = 0;
    check("R9 eoi strobe", {31'h0, eoiValid}, 1);
    check("R9 eoi vector", {24'h0, eoiVector}, 32'h5A);
    wr(12'h040, 1, 32'h77);
    check("R9 short eoi ignored", {31'h0, eoiValid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset();
    tDecode();
    tRegs();
    tEntries();
    tRemote();
    tEoi();
    doneFlag = 1;
  end

  initial begin
    fork
      wait (doneFlag);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule